// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Bank

This block holds a small set of protection registers that sit beside a flash array. There are `N_USER` wide user registers (128 bits each by default) and a pair of half-width registers (64 bits each by default). One of the half-width registers is a read-only unique number, fixed by a parameter. The other is user-programmable. Two lock words decide which of these registers may still be changed.

All storage is reached through 16-bit words. A single-cycle program strobe writes one word, and a combinational read port returns any word. Programming can only clear bits, so the stored value becomes the old value ANDed with the data. Programs that the lock rules or the address map refuse leave the storage unchanged and set a sticky error flag. The lock words follow the same one-way rule, so a register that is locked stays locked. The lock bit of the unique-number register is already in the locked state at start-up.

Top module: `otp_reg_bank`

## Requirements
- R1: After reset every user word reads all ones, the lock word for the half registers reads 0xFFFE and the lock word for the wide registers reads all ones.
- R2: Word map, ascending: wide register k occupies words k*WPR..k*WPR+WPR-1, least significant word first (WPR = USER_W/16). Next come HWPR unique-number words (HWPR = HALF_W/16), then HWPR words of the user half register, then the half-lock word, then the wide-lock word. Every higher address reads all ones.
- R3: The unique-number words read slices of parameter `UID`, least significant first. A program to them never changes them and sets the error flag.
- R4: A program to an unlocked user word stores old AND data. A 1 in the data never returns a cleared bit to 1, and such a program does not set the error flag.
- R5: Bit k of the wide-lock word locks wide register k when it is 0. Programs to a locked register leave it unchanged and set the error flag. Other registers stay programmable.
- R6: Bit 1 of the half-lock word locks the user half register when it is 0. Bit 0 is the unique-number lock and always reads 0.
- R7: Both lock words are programmed by AND and can never return to 1. Bits with no lock meaning read 1 and cannot be cleared.
- R8: A program to an address above the wide-lock word changes nothing and sets the error flag.
- R9: The error flag is 0 after reset, rises in the cycle after a refused program, and stays 1 until reset.
- R10: Reads are combinational from `rd_addr_i`. A program takes effect at the rising clock edge where `prog_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_i | input | 1 | Program strobe, one word per cycle |
| prog_addr_i | input | ADDR_W | Word address of the program |
| prog_data_i | input | 16 | Program data, ANDed into the word |
| rd_addr_i | input | ADDR_W | Word address to read |
| rd_data_o | output | 16 | Read data |
| err_o | output | 1 | Sticky refused-program flag |

## Verification
The bench builds the block with four 32-bit wide registers and 32-bit half registers. This gives 14 mapped words inside a 32-word address space. At that size every mapped word can be programmed twice with distinct patterns and checked against an AND model. Every unmapped address can be read and programmed as well. Each lock bit is exercised across a reset, and the unique-number slices are compared against the parameter directly.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    RG_USR, RG_UID, RG_U64, RG_LKA, RG_LKB, RG_NONE
  } region_e;
endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec
  import otp_pkg::*;
#(
  parameter int N_USER = 16,
  parameter int WPR    = 8,
  parameter int HWPR   = 4,
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 8,
  parameter int REG_W  = 4,
  parameter int HW_W   = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [HW_W-1:0]   half_o
);
  localparam int USR_END = N_USER * WPR;
  localparam int UID_END = USR_END + HWPR;
  localparam int U64_END = UID_END + HWPR;

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_comb begin
    if (a32 < USR_END)       region_o = RG_USR;
    else if (a32 < UID_END)  region_o = RG_UID;
    else if (a32 < U64_END)  region_o = RG_U64;
    else if (a32 == U64_END) region_o = RG_LKA;
    else if (a32 == U64_END + 1) region_o = RG_LKB;
    else                     region_o = RG_NONE;
  end

  // store holds wide words then user-half words; the uid gap is skipped
  assign idx_o  = (a32 < USR_END) ? IDX_W'(a32) : IDX_W'(a32 - HWPR);
  assign reg_o  = REG_W'(a32 / WPR);
  assign half_o = HW_W'(a32 - USR_END);
endmodule

// File: rtl/otp_word_store.sv
module otp_word_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 132,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem_q[i] <= '1;
      else if (we_i && (32'(wr_idx_i) == i))          mem_q[i] <= mem_q[i] & wr_data_i;
    end
  end

  assign rd_data_o = (32'(rd_idx_i) < DEPTH) ? mem_q[rd_idx_i] : '1;
endmodule

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl #(
  parameter int WORD_W = 16,
  parameter int N_USER = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              u64_open_o,
  output logic [N_USER-1:0] lock_b_o,
  output logic [WORD_W-1:0] lka_word_o,
  output logic [WORD_W-1:0] lkb_word_o
);
  logic              u64_q;
  logic [N_USER-1:0] lkb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u64_q <= 1'b1;
      lkb_q <= '1;
    end else begin
      if (wr_a_i) u64_q <= u64_q & data_i[1];
      if (wr_b_i) lkb_q <= lkb_q & data_i[N_USER-1:0];
    end
  end

  always_comb begin
    lka_word_o    = '1;
    lka_word_o[0] = 1'b0;  // uid lock preset
    lka_word_o[1] = u64_q;
    lkb_word_o    = '1;
    lkb_word_o[N_USER-1:0] = lkb_q;
  end

  assign u64_open_o = u64_q;
  assign lock_b_o   = lkb_q;
endmodule

// File: rtl/otp_reg_bank.sv
module otp_reg_bank
  import otp_pkg::*;
#(
  parameter int N_USER = 16,
  parameter int USER_W = 128,
  parameter int HALF_W = 64,
  parameter logic [HALF_W-1:0] UID = 64'h5A3C_9E1F_0D72_B486,
  parameter int WORD_W = 16,
  parameter int ADDR_W = $clog2(N_USER*(USER_W/16) + 2*(HALF_W/16) + 2) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [WORD_W-1:0] prog_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              err_o
);
  localparam int WPR   = USER_W / WORD_W;
  localparam int HWPR  = HALF_W / WORD_W;
  localparam int DEPTH = N_USER * WPR + HWPR;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int REG_W = (N_USER > 1) ? $clog2(N_USER + 1) : 1;
  localparam int HW_W  = (HWPR > 1) ? $clog2(HWPR) : 1;

  region_e           p_region, r_region;
  logic [IDX_W-1:0]  p_idx, r_idx;
  logic [REG_W-1:0]  p_reg, r_reg;
  logic [HW_W-1:0]   p_half, r_half;

  otp_addr_dec #(.N_USER(N_USER), .WPR(WPR), .HWPR(HWPR), .ADDR_W(ADDR_W),
                 .IDX_W(IDX_W), .REG_W(REG_W), .HW_W(HW_W)) u_pdec (
    .addr_i(prog_addr_i), .region_o(p_region), .idx_o(p_idx),
    .reg_o(p_reg), .half_o(p_half));

  otp_addr_dec #(.N_USER(N_USER), .WPR(WPR), .HWPR(HWPR), .ADDR_W(ADDR_W),
                 .IDX_W(IDX_W), .REG_W(REG_W), .HW_W(HW_W)) u_rdec (
    .addr_i(rd_addr_i), .region_o(r_region), .idx_o(r_idx),
    .reg_o(r_reg), .half_o(r_half));

  logic              u64_open;
  logic [N_USER-1:0] lock_b_q;
  logic [WORD_W-1:0] lka_word, lkb_word, store_rd;
  logic              refused, store_we;

  always_comb begin
    unique case (p_region)
      RG_USR:  refused = !lock_b_q[p_reg];
      RG_U64:  refused = !u64_open;
      RG_LKA, RG_LKB: refused = 1'b0;
      default: refused = 1'b1;
    endcase
  end

  assign store_we = prog_i && !refused && (p_region == RG_USR || p_region == RG_U64);

  otp_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni, .we_i(store_we), .wr_idx_i(p_idx), .wr_data_i(prog_data_i),
    .rd_idx_i(r_idx), .rd_data_o(store_rd));

  otp_lock_ctrl #(.WORD_W(WORD_W), .N_USER(N_USER)) u_lock (
    .clk_i, .rst_ni,
    .wr_a_i(prog_i && p_region == RG_LKA),
    .wr_b_i(prog_i && p_region == RG_LKB),
    .data_i(prog_data_i), .u64_open_o(u64_open), .lock_b_o(lock_b_q),
    .lka_word_o(lka_word), .lkb_word_o(lkb_word));

  always_comb begin
    unique case (r_region)
      RG_USR, RG_U64: rd_data_o = store_rd;
      RG_UID:  rd_data_o = UID[r_half*WORD_W +: WORD_W];
      RG_LKA:  rd_data_o = lka_word;
      RG_LKB:  rd_data_o = lkb_word;
      default: rd_data_o = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_o <= 1'b0;
    else if (prog_i && refused) err_o <= 1'b1;
  end

  logic unused_r_reg;
  assign unused_r_reg = ^r_reg;
endmodule

// File: rtl/otp_reg_bank_chk.sv
module otp_reg_bank_chk
  import otp_pkg::*;
#(
  parameter int N_USER = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_i,
  input logic              err_o,
  input logic              refused,
  input logic              store_we,
  input region_e           p_region,
  input logic [N_USER-1:0] lock_b_q
);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_refuse_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && refused) |=> err_o);
  assert_uid_nowrite_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && p_region == RG_UID) |-> (!store_we && refused));
  assert_oor_refused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && p_region == RG_NONE) |-> (!store_we && refused));
  assert_lock_onlyfall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_b_q & ~$past(lock_b_q)) == '0));
  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_i |=> $stable(lock_b_q));
endmodule

bind otp_reg_bank otp_reg_bank_chk #(.N_USER(N_USER)) u_chk (.*);

// File: tb/otp_reg_bank_bench.sv
`timescale 1ns/1ps
module otp_reg_bank_bench;
  localparam int N_USER = 4;
  localparam int USER_W = 32;
  localparam int HALF_W = 32;
  localparam logic [31:0] UIDV = 32'hA5C3_1E72;
  localparam int AW = 5;
  localparam int LKA = 12;
  localparam int LKB = 13;

  logic clk = 0, rst_n = 0, prog = 0;
  logic [AW-1:0] paddr = '0, raddr = '0;
  logic [15:0] pdata = '0, rdata;
  logic err;
  int checks = 0, fails = 0;
  logic [15:0] exp_m [32];

  always #2.5 clk = ~clk;

  otp_reg_bank #(.N_USER(N_USER), .USER_W(USER_W), .HALF_W(HALF_W), .UID(UIDV))
    u_otp_reg_bank (.clk_i(clk), .rst_ni(rst_n), .prog_i(prog), .prog_addr_i(paddr),
      .prog_data_i(pdata), .rd_addr_i(raddr), .rd_data_o(rdata), .err_o(err));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < 32; a++) exp_m[a] = 16'hFFFF;
    exp_m[8]  = UIDV[15:0];
    exp_m[9]  = UIDV[31:16];
    exp_m[LKA] = 16'hFFFE;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; #3; rst_n = 1;
    model_reset();
  endtask

  task automatic prg(input int a, input logic [15:0] d);
    @(negedge clk); prog = 1; paddr = AW'(a); pdata = d;
    @(negedge clk); prog = 0;
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 32; a++) begin
      raddr = AW'(a); #0.5;
      chk(tag, rdata, exp_m[a]);
    end
  endtask

  function automatic bit user_word(input int a);
    return (a < 8) || (a == 10) || (a == 11);
  endfunction

  initial begin
    model_reset();
    #7; rst_n = 1;
    @(negedge clk);
    chk("R9 err after reset", {15'b0, err}, 16'h0);
    sweep("R1 R2 R3 reset map");

    // R4 two AND passes
    for (int a = 0; a < 32; a++) if (user_word(a)) begin
      logic [15:0] d = ~(16'h0101 * 16'(a + 1));
      prg(a, d); exp_m[a] &= d;
    end
    sweep("R4 pass1");
    for (int a = 0; a < 32; a++) if (user_word(a)) begin
      logic [15:0] d = 16'hF0F0 ^ 16'(a * 3);
      prg(a, d); exp_m[a] &= d;
    end
    sweep("R4 pass2");
    chk("R4 no err", {15'b0, err}, 16'h0);

    // R10 program visible right after its edge
    @(negedge clk); prog = 1; paddr = 5'd0; pdata = 16'h0000; raddr = 5'd0;
    @(posedge clk); #0.5; prog = 0; exp_m[0] = 16'h0000;
    chk("R10 edge effect", rdata, 16'h0000);

    // R3 uid program refused
    prg(8, 16'h0000);
    sweep("R3 uid unchanged");
    chk("R3 R9 err set", {15'b0, err}, 16'h1);
    prg(0, 16'hFFFF);
    chk("R9 err sticky", {15'b0, err}, 16'h1);

    // R5 lock wide reg 2
    do_reset();
    chk("R9 err cleared", {15'b0, err}, 16'h0);
    prg(LKB, 16'hFFFB); exp_m[LKB] = 16'hFFFB;
    chk("R5 lock prog no err", {15'b0, err}, 16'h0);
    prg(4, 16'h0000); prg(5, 16'h1234);
    prg(6, 16'h00FF); exp_m[6] = 16'h00FF;
    prg(LKB, 16'h0004 | 16'hFFF0); exp_m[LKB] = 16'hFFF0;
    prg(LKB, 16'hFFFF);
    sweep("R5 R7 lock b");
    chk("R5 err set", {15'b0, err}, 16'h1);

    // R6 R7 lock half register
    do_reset();
    prg(10, 16'h8001); exp_m[10] = 16'h8001;
    prg(LKA, 16'h0000); exp_m[LKA] = 16'hFFFC;
    chk("R6 lock prog no err", {15'b0, err}, 16'h0);
    prg(LKA, 16'hFFFF);
    prg(10, 16'h0000); prg(11, 16'h0000);
    sweep("R6 R7 lock a");
    chk("R6 err set", {15'b0, err}, 16'h1);

    // R8 out-of-range
    for (int a = 14; a < 32; a++) begin
      do_reset();
      prg(a, 16'h0000);
      chk("R8 err", {15'b0, err}, 16'h1);
    end
    sweep("R8 map intact");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule